// File: doc/BRIEF.md
# Interrupt Sense Normalizer Bank

This block conditions a bank of interrupt request lines before they reach an interrupt controller. That controller only understands active-high levels and rising edges. Each line has its own enable bit and a 3-bit sense code. The block synchronizes every input and applies the pin's sense code. It inverts active-low levels and turns falling-edge and both-edge events into single-cycle high pulses, so only active-high levels and rising edges leave the bank.

Software sets up the bank through a small 32-bit register port with byte addresses. Enable bits sit in packed bank words, 32 pins per word. Each pin also has a configuration word of its own. A pin is switched off by writing its bank word back with that bit cleared. This leaves its sense code untouched, so the pin comes back in the same mode when it is re-enabled.

Top module: `irq_sense_norm`

## Requirements
- R1: After reset every enable bit and every configuration word reads zero and every output is low.
- R2: Enable bank word w sits at byte address 0x10 + 4*w, and pin n is bit n%32 of word n/32. A write replaces the whole word, and bits for pins at or above the pin count read zero.
- R3: The configuration word of pin n sits at byte address 0x110 + 4*n. Only bits [2:0] are stored, and bits [31:3] read zero.
- R4: A read issued in one cycle shows its data on the read-data port in the next cycle. A read that coincides with a write to the same register returns the old value. Unmapped or unaligned addresses return zero, and the port shows zero after any cycle with no read.
- R5: Sense code 100 (level, active high): the output follows the input, two clock edges after the input changes.
- R6: Sense code 000 (level, active low): the output is the inverse of the input, with the same two-edge latency.
- R7: Sense code 110 (rising edge): each low-to-high input transition gives exactly one single-cycle high pulse, two edges after the change.
- R8: Sense code 010 (falling edge): each high-to-low transition gives exactly one single-cycle high pulse.
- R9: Sense code 111 (both edges): every transition in either direction gives one single-cycle high pulse.
- R10: The undefined codes 001, 011 and 101 hold the output low whatever the input does.
- R11: A clear enable bit forces the pin's output low from the cycle after the write and leaves its configuration word unchanged. This also holds when the clearing write lands in the same cycle as an edge that would otherwise pulse.
- R12: Writing a new sense code, or re-enabling a pin, while its input is steady never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd_en |
| irq_in | input | NUM_PINS | Raw interrupt inputs, asynchronous |
| irq_out | output | NUM_PINS | Normalized outputs: active-high levels or rising-edge pulses |

## Verification
Two events can fall in the same clock edge: a register write that clears a pin's enable, and the arrival of a synchronized edge on that pin. The bench starts an input transition one cycle early, then issues the enable-clearing write so that it commits on the edge where the transition leaves the synchronizer. It judges the result by demanding a low output on that cycle and the next. It also re-enables the pin with the input steady and demands that no late pulse appears. A second pairing covers a sense-code rewrite and a steady high input on the same pin: every code change must leave the output free of pulses.

// File: rtl/isn_pkg.sv
package isn_pkg;

   // Register layout (byte addresses)
   localparam int EN_BASE  = 'h010;
   localparam int CFG_BASE = 'h110;

   // Sense codes
   localparam logic [2:0] SENSE_LVL_LO = 3'b000;
   localparam logic [2:0] SENSE_FALL   = 3'b010;
   localparam logic [2:0] SENSE_LVL_HI = 3'b100;
   localparam logic [2:0] SENSE_RISE   = 3'b110;
   localparam logic [2:0] SENSE_BOTH   = 3'b111;

   // Bits of bank word b that map onto existing pins
   function automatic logic [31:0] bank_mask(input int num_pins, input int b);
      logic [31:0] m;
      for (int j = 0; j < 32; j++) m[j] = ((b * 32 + j) < num_pins);
      return m;
   endfunction

endpackage

// File: rtl/isn_sync.sv
module isn_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stage_q [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= stage_q[k-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/isn_regs.sv
module isn_regs
   import isn_pkg::*;
#(
   parameter int NUM_PINS = 126,
   parameter int ADDR_W   = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [31:0]           wdata,
   output logic [31:0]           rdata,
   output logic [NUM_PINS-1:0]   pin_en,
   output logic [NUM_PINS*3-1:0] pin_cfg
);
   localparam int NBANK = (NUM_PINS + 31) / 32;

   logic [31:0] en_q  [NBANK];
   logic [2:0]  cfg_q [NUM_PINS];
   logic [31:0] rd_word;

   // Enable bank words; bits without a pin are masked on write
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam logic [ADDR_W-1:0] BANK_ADDR = ADDR_W'(EN_BASE + 4 * b);
      localparam logic [31:0]       BANK_MASK = bank_mask(NUM_PINS, b);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          en_q[b] <= '0;
         else if (wr_en && addr == BANK_ADDR) en_q[b] <= wdata & BANK_MASK;
      end
   end

   // Per-pin configuration words, three stored bits each
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
      localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CFG_BASE + 4 * i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         cfg_q[i] <= SENSE_LVL_LO;
         else if (wr_en && addr == CFG_ADDR) cfg_q[i] <= wdata[2:0];
      end
      assign pin_en[i]          = en_q[i / 32][i % 32];
      assign pin_cfg[i*3 +: 3]  = cfg_q[i];
   end

   // Read decode: exact address match only
   always_comb begin
      rd_word = '0;
      for (int b = 0; b < NBANK; b++)
         if (addr == ADDR_W'(EN_BASE + 4 * b)) rd_word = en_q[b];
      for (int i = 0; i < NUM_PINS; i++)
         if (addr == ADDR_W'(CFG_BASE + 4 * i)) rd_word = {29'd0, cfg_q[i]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word;
      else            rdata <= '0;
   end
endmodule

// File: rtl/isn_pin.sv
module isn_pin
   import isn_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_in,
   input  logic       enable,
   input  logic [2:0] sense,
   output logic       irq
);
   // Edge history tracks the synchronized input on every cycle, so a
   // change of sense code compares two equal samples and cannot pulse.
   logic hist_q;
   logic raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= sync_in;
   end

   always_comb begin
      unique case (sense)
         SENSE_LVL_HI: raw = sync_in;
         SENSE_LVL_LO: raw = ~sync_in;
         SENSE_RISE:   raw = sync_in & ~hist_q;
         SENSE_FALL:   raw = ~sync_in & hist_q;
         SENSE_BOTH:   raw = sync_in ^ hist_q;
         default:      raw = 1'b0;
      endcase
   end

   assign irq = enable & raw;
endmodule

// File: rtl/irq_sense_norm.sv
module irq_sense_norm
   import isn_pkg::*;
#(
   parameter int NUM_PINS    = 126,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr_en,
   input  logic                reg_rd_en,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [NUM_PINS-1:0] irq_in,
   output logic [NUM_PINS-1:0] irq_out
);
   localparam int NBANK    = (NUM_PINS + 31) / 32;
   localparam int CFG_END  = CFG_BASE + 4 * NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > 126) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..126");
   end
   if (EN_BASE + 4 * NBANK > CFG_BASE) begin : g_bad_banks
      $error("enable banks overlap configuration words");
   end
   if (CFG_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the configuration words");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0]   pin_en;
   logic [NUM_PINS*3-1:0] pin_cfg;
   logic [NUM_PINS-1:0]   irq_sync;

   isn_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .rd_en   (reg_rd_en),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .pin_en  (pin_en),
      .pin_cfg (pin_cfg)
   );

   isn_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (irq_in),
      .dout  (irq_sync)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      isn_pin pin_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .sync_in (irq_sync[i]),
         .enable  (pin_en[i]),
         .sense   (pin_cfg[i*3 +: 3]),
         .irq     (irq_out[i])
      );
   end
endmodule

// File: rtl/irq_sense_norm_chk.sv
module irq_sense_norm_chk
   import isn_pkg::*;
#(
   parameter int NUM_PINS = 126
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_rd_en,
   input logic [31:0]           reg_rdata,
   input logic [NUM_PINS-1:0]   irq_out,
   input logic [NUM_PINS-1:0]   pin_en,
   input logic [NUM_PINS*3-1:0] pin_cfg
);
   assert_disabled_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~pin_en) == '0);

   assert_idle_rdata_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_en |=> reg_rdata == 32'd0);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
      logic [2:0] sense;
      assign sense = pin_cfg[i*3 +: 3];

      assert_undef_code_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (sense == 3'b001 || sense == 3'b011 || sense == 3'b101) |-> !irq_out[i]);

      assert_rise_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_out[i] && sense == SENSE_RISE) |=> (sense != SENSE_RISE || !irq_out[i]));

      assert_fall_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_out[i] && sense == SENSE_FALL) |=> (sense != SENSE_FALL || !irq_out[i]));
   end
endmodule

bind irq_sense_norm irq_sense_norm_chk #(.NUM_PINS(NUM_PINS)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_rd_en (reg_rd_en),
   .reg_rdata (reg_rdata),
   .irq_out   (irq_out),
   .pin_en    (pin_en),
   .pin_cfg   (pin_cfg)
);

// File: tb/irq_sense_norm_tb_top.sv
module irq_sense_norm_tb_top;
   localparam int NP = 40;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic          reg_rd_en = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NP-1:0] irq_in = '0;
   logic [NP-1:0] irq_out;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;
   logic [31:0] bank_model [2];

   always #2.5 clk = ~clk;

   irq_sense_norm #(.NUM_PINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr_en (reg_wr_en),
      .reg_rd_en (reg_rd_en),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_in    (irq_in),
      .irq_out   (irq_out)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      tick();
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      reg_addr = a; reg_rd_en = 1'b1;
      tick();
      reg_rd_en = 1'b0;
      d = reg_rdata;
   endtask

   function automatic logic [AW-1:0] cfg_addr(input int pin);
      return AW'('h110 + 4 * pin);
   endfunction

   function automatic logic [AW-1:0] bank_addr(input int w);
      return AW'('h10 + 4 * w);
   endfunction

   function automatic bit exp_bit(input logic [2:0] code, input bit s, input bit p);
      case (code)
         3'b100: return s;
         3'b000: return !s;
         3'b110: return s && !p;
         3'b010: return !s && p;
         3'b111: return s != p;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string code_tag(input logic [2:0] code);
      case (code)
         3'b100: return "R5";
         3'b000: return "R6";
         3'b110: return "R7";
         3'b010: return "R8";
         3'b111: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [63:0] one_pin(input int pin, input bit v);
      logic [63:0] e = '0;
      e[pin] = v;
      return e;
   endfunction

   task automatic set_en(input int pin, input bit v);
      bank_model[pin / 32][pin % 32] = v;
      wr(bank_addr(pin / 32), bank_model[pin / 32]);
   endtask

   // Sweep one pin through one code: steady low, rise, fall
   task automatic run_mode(input int pin, input logic [2:0] code);
      string t;
      t = code_tag(code);
      irq_in = '0;
      wr(cfg_addr(pin), {29'd0, code});
      set_en(pin, 1'b1);
      repeat (3) tick();
      chk(t, 64'(irq_out), one_pin(pin, exp_bit(code, 0, 0)));
      irq_in[pin] = 1'b1;
      tick();
      chk(t, 64'(irq_out), one_pin(pin, exp_bit(code, 0, 0)));
      tick();
      chk(t, 64'(irq_out), one_pin(pin, exp_bit(code, 1, 0)));
      tick();
      chk(t, 64'(irq_out), one_pin(pin, exp_bit(code, 1, 1)));
      irq_in[pin] = 1'b0;
      repeat (2) tick();
      chk(t, 64'(irq_out), one_pin(pin, exp_bit(code, 0, 1)));
      tick();
      chk(t, 64'(irq_out), one_pin(pin, exp_bit(code, 0, 0)));
      set_en(pin, 1'b0);
      wr(cfg_addr(pin), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      bank_model[0] = '0;
      bank_model[1] = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      chk("R1", 64'(irq_out), 64'd0);
      rd(bank_addr(0), d); chk("R1", 64'(d), 64'd0);
      rd(bank_addr(1), d); chk("R1", 64'(d), 64'd0);
      rd(cfg_addr(0), d);  chk("R1", 64'(d), 64'd0);
      rd(cfg_addr(39), d); chk("R1", 64'(d), 64'd0);

      // R2: bank layout and masking of absent pins
      wr(bank_addr(0), 32'hA5A5_0F0F);
      rd(bank_addr(0), d); chk("R2", 64'(d), 64'hA5A5_0F0F);
      wr(bank_addr(1), 32'hFFFF_FFFF);
      rd(bank_addr(1), d); chk("R2", 64'(d), 64'h0000_00FF);
      wr(bank_addr(0), 32'd0);
      wr(bank_addr(1), 32'd0);
      rd(bank_addr(0), d); chk("R2", 64'(d), 64'd0);

      // R3: config words keep three bits
      wr(cfg_addr(39), 32'hFFFF_FFF9);
      rd(cfg_addr(39), d); chk("R3", 64'(d), 64'd1);
      wr(cfg_addr(5), 32'h0000_0006);
      rd(cfg_addr(5), d);  chk("R3", 64'(d), 64'd6);
      rd(cfg_addr(39), d); chk("R3", 64'(d), 64'd1);
      wr(cfg_addr(39), 32'd0);

      // R4: unmapped, unaligned, idle cycle, read during write
      rd(AW'('h000), d); chk("R4", 64'(d), 64'd0);
      rd(AW'('h018), d); chk("R4", 64'(d), 64'd0);
      rd(cfg_addr(40), d); chk("R4", 64'(d), 64'd0);
      rd(AW'('h116), d); chk("R4", 64'(d), 64'd0);
      rd(cfg_addr(5), d);  chk("R4", 64'(d), 64'd6);
      tick();
      chk("R4", 64'(reg_rdata), 64'd0);
      reg_addr = cfg_addr(5); reg_wdata = 32'd2; reg_wr_en = 1'b1; reg_rd_en = 1'b1;
      tick();
      reg_wr_en = 1'b0; reg_rd_en = 1'b0;
      chk("R4", 64'(reg_rdata), 64'd6);
      rd(cfg_addr(5), d); chk("R4", 64'(d), 64'd2);
      wr(cfg_addr(5), 32'd0);

      // R5..R10: every code on pins at bank edges
      foreach (bank_model[w]) bank_model[w] = '0;
      for (int pi = 0; pi < 4; pi++) begin
         int pin;
         pin = (pi == 0) ? 0 : (pi == 1) ? 31 : (pi == 2) ? 32 : 39;
         for (int c = 0; c < 8; c++) run_mode(pin, 3'(c));
      end

      // R11: enable clear blocks output, config retained
      wr(cfg_addr(3), 32'd4);
      irq_in[3] = 1'b1;
      set_en(3, 1'b1);
      repeat (3) tick();
      chk("R11", 64'(irq_out), one_pin(3, 1));
      set_en(3, 1'b0);
      chk("R11", 64'(irq_out), 64'd0);
      rd(cfg_addr(3), d); chk("R11", 64'(d), 64'd4);
      set_en(3, 1'b1);
      chk("R11", 64'(irq_out), one_pin(3, 1));

      // R11: clearing write on the same edge a rising edge emerges
      irq_in[3] = 1'b0;
      wr(cfg_addr(3), 32'd6);
      repeat (3) tick();
      chk("R11", 64'(irq_out), 64'd0);
      irq_in[3] = 1'b1;
      tick();
      set_en(3, 1'b0);
      chk("R11", 64'(irq_out), 64'd0);
      tick();
      chk("R11", 64'(irq_out), 64'd0);
      // R12: re-enable with steady input gives no late pulse
      set_en(3, 1'b1);
      chk("R12", 64'(irq_out), 64'd0);
      tick();
      chk("R12", 64'(irq_out), 64'd0);

      // R12: code changes with steady input
      wr(cfg_addr(3), 32'd4);
      chk("R12", 64'(irq_out), one_pin(3, 1));
      wr(cfg_addr(3), 32'd6);
      chk("R12", 64'(irq_out), 64'd0);
      wr(cfg_addr(3), 32'd7);
      chk("R12", 64'(irq_out), 64'd0);
      wr(cfg_addr(3), 32'd2);
      chk("R12", 64'(irq_out), 64'd0);
      irq_in[3] = 1'b0;
      wr(cfg_addr(3), 32'd0);
      repeat (3) tick();
      chk("R12", 64'(irq_out), one_pin(3, 1));
      wr(cfg_addr(3), 32'd2);
      chk("R12", 64'(irq_out), 64'd0);
      wr(cfg_addr(3), 32'd7);
      chk("R12", 64'(irq_out), 64'd0);
      tick();
      chk("R12", 64'(irq_out), 64'd0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule